// File: doc/BRIEF.md
# Device State Control Unit

This unit switches on-chip peripherals on and off by device number. A requester presents a device ID and an operation, either enable or disable. The unit looks the ID up in a table of ranges. Each range gives the control word, the first bit, the field width per device and the codes to write. The unit then rewrites that device's field inside the control word and answers, one cycle later, whether the request was taken.

A second table maps device IDs to fields in status words that the peripherals drive. A query port reports whether a device reads back as enabled, disabled or in some other state. It also reports when the ID has no status field at all.

The range tables sit in a package. The default table holds three control ranges across two control words and two status ranges across two status words. Some devices in the default table can be switched on but never switched off.

Top module: `devstate_ctl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both control words become 0 and `rsp_valid` becomes 0.
- R2: An enable request for ID n in 0..11 is accepted and writes 2'b01 into bits [2n+1:2n] of `ctrl_word0`.
- R3: A request for ID 12 is accepted and writes bits [31:30] of `ctrl_word0`: 2'b11 to enable and 2'b00 to disable.
- R4: An enable request for ID 13 or 14 is accepted and sets bit (ID−13) of `ctrl_word1`.
- R5: A disable request for ID n in 0..11 is accepted and writes 2'b00 into bits [2n+1:2n] of `ctrl_word0`.
- R6: A disable request (`req_op`=0) for ID 13 or 14 is rejected, and both control words stay as they were.
- R7: A request for any ID above 14 is rejected, and both control words stay as they were.
- R8: An accepted request changes only the addressed field; all other bits of both words keep their value. A cycle with `req_valid` low changes no control bit.
- R9: `rsp_valid` is high for exactly the cycle after each edge at which `req_valid` was high. In that cycle `rsp_ok` is 1 for accepted requests and 0 for rejected ones, and the control words already hold the result.
- R10: For `qry_id` n in 0..9, the status field is bits [3n+2:3n] of `stat_word0`. `qry_state` is 2'b01 (enabled) when the field is 1, 2'b00 (disabled) when it is 0, and 2'b10 (unknown) for any other value. The output is combinational.
- R11: For `qry_id` n in 10..11, the status field is bits [3(n−10)+2:3(n−10)] of `stat_word1`. It is classified with the same codes as R10.
- R12: For `qry_id` above 11, `qry_state` is 2'b11 (no status field), whatever the status words hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_id | input | 5 | Device ID of the request |
| req_op | input | 1 | 1 = enable, 0 = disable |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_ok | output | 1 | 1 = accepted, 0 = rejected |
| qry_id | input | 5 | Device ID to classify |
| qry_state | output | 2 | 00 disabled, 01 enabled, 10 unknown, 11 no status field |
| stat_word0 | input | 32 | First status word from the peripherals |
| stat_word1 | input | 32 | Second status word from the peripherals |
| ctrl_word0 | output | 32 | First control word |
| ctrl_word1 | output | 32 | Second control word |

## Verification
The bench builds the unit with its default 5-bit ID and the default range tables. With that build, all 32 IDs can be swept, including the 17 IDs that fall outside every control range. Each ID gets enable, disable and re-enable requests while earlier fields stay populated, so any disturbance of a neighbouring field shows up at once. The status port is swept over every ID and every 3-bit field value on a non-zero background. This reaches the enabled, disabled and unknown codes and the unmapped case.

// File: rtl/devstate_pkg.sv
// devstate_pkg: shared types and the range tables of the device state unit.
// Assumes ranges inside one table do not overlap and fields fit in a word.
package devstate_pkg;

    localparam int WORD_W    = 32;
    localparam int NUM_WORDS = 2;
    localparam int WSEL_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int LSB_W     = $clog2(WORD_W);

    // Marks a range whose devices cannot be switched off.
    localparam logic [WORD_W-1:0] NO_DISABLE = '1;

    typedef struct packed {
        logic [7:0]        base_id;
        logic [7:0]        n_ids;
        logic [WSEL_W-1:0] word;
        logic [WORD_W-1:0] on_code;
        logic [WORD_W-1:0] off_code;
        logic [LSB_W-1:0]  first_bit;
        logic [6:0]        fld_w;
    } range_t;

    localparam int CTL_N  = 3;
    localparam int STAT_N = 2;

    localparam range_t [CTL_N-1:0] CTL_TAB = '{
        0: '{base_id: 8'd0,  n_ids: 8'd12, word: 1'b0, on_code: 32'd1,
             off_code: 32'd0, first_bit: 5'd0,  fld_w: 7'd2},
        1: '{base_id: 8'd12, n_ids: 8'd1,  word: 1'b0, on_code: 32'd3,
             off_code: 32'd0, first_bit: 5'd30, fld_w: 7'd2},
        2: '{base_id: 8'd13, n_ids: 8'd2,  word: 1'b1, on_code: 32'd1,
             off_code: NO_DISABLE, first_bit: 5'd0, fld_w: 7'd1}
    };

    localparam range_t [STAT_N-1:0] STAT_TAB = '{
        0: '{base_id: 8'd0,  n_ids: 8'd10, word: 1'b0, on_code: 32'd1,
             off_code: 32'd0, first_bit: 5'd0, fld_w: 7'd3},
        1: '{base_id: 8'd10, n_ids: 8'd2,  word: 1'b1, on_code: 32'd1,
             off_code: 32'd0, first_bit: 5'd0, fld_w: 7'd3}
    };

    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_ON    = 2'b01,
        ST_OTHER = 2'b10,
        ST_NONE  = 2'b11
    } dev_state_e;

endpackage

// File: rtl/devstate_field_decode.sv
// devstate_field_decode: maps an ID onto a range table entry and yields the
// field position, mask and the codes truncated to the field width.
// Assumes non-overlapping ranges; the first matching entry wins.
module devstate_field_decode
    import devstate_pkg::*;
#(
    parameter int ID_W = 5,
    parameter int N    = 1,
    parameter range_t [N-1:0] TAB = '0
) (
    input  logic [ID_W-1:0]   id,
    output logic              hit,
    output logic [WSEL_W-1:0] wsel,
    output logic [LSB_W-1:0]  lsb,
    output logic [WORD_W-1:0] mask,
    output logic [WORD_W-1:0] on_code,
    output logic [WORD_W-1:0] off_code,
    output logic              can_off
);

    // Range search and field arithmetic.
    always_comb begin
        int unsigned idv;
        int unsigned pos;
        hit      = 1'b0;
        wsel     = '0;
        lsb      = '0;
        mask     = '0;
        on_code  = '0;
        off_code = '0;
        can_off  = 1'b0;
        pos      = 0;
        idv      = 32'(id);
        for (int i = 0; i < N; i++) begin
            if (!hit && idv >= 32'(TAB[i].base_id) &&
                idv < 32'(TAB[i].base_id) + 32'(TAB[i].n_ids)) begin
                hit      = 1'b1;
                wsel     = TAB[i].word;
                pos      = (idv - 32'(TAB[i].base_id)) * 32'(TAB[i].fld_w)
                           + 32'(TAB[i].first_bit);
                lsb      = pos[LSB_W-1:0];
                mask     = (32'(TAB[i].fld_w) >= WORD_W) ? '1
                           : ((WORD_W'(1) << TAB[i].fld_w) - WORD_W'(1));
                on_code  = TAB[i].on_code & mask;
                off_code = TAB[i].off_code & mask;
                can_off  = (TAB[i].off_code != NO_DISABLE);
            end
        end
    end

endmodule

// File: rtl/devstate_ctl_regs.sv
// devstate_ctl_regs: the control words, each updated by a single-cycle
// read-modify-write of one field. Assumes code is already within mask.
module devstate_ctl_regs
    import devstate_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  logic [WSEL_W-1:0]                wsel,
    input  logic [LSB_W-1:0]                 lsb,
    input  logic [WORD_W-1:0]                mask,
    input  logic [WORD_W-1:0]                code,
    output logic [NUM_WORDS-1:0][WORD_W-1:0] words
);

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] q;

        // Reset the word or splice the new field into it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && 32'(wsel) == g)
                q <= (q & ~(mask << lsb)) | (code << lsb);
        end

        assign words[g] = q;
    end

endmodule

// File: rtl/devstate_stat_class.sv
// devstate_stat_class: extracts a status field and classifies it against
// the range's on and off codes. Purely combinational.
module devstate_stat_class
    import devstate_pkg::*;
(
    input  logic [NUM_WORDS-1:0][WORD_W-1:0] words,
    input  logic                             hit,
    input  logic [WSEL_W-1:0]                wsel,
    input  logic [LSB_W-1:0]                 lsb,
    input  logic [WORD_W-1:0]                mask,
    input  logic [WORD_W-1:0]                on_code,
    input  logic [WORD_W-1:0]                off_code,
    output logic [1:0]                       state
);

    logic [WORD_W-1:0] field;

    // Pull the field out of the selected word and name its state.
    always_comb begin
        field = (words[wsel] >> lsb) & mask;
        if (!hit)                  state = ST_NONE;
        else if (field == on_code) state = ST_ON;
        else if (field == off_code) state = ST_OFF;
        else                       state = ST_OTHER;
    end

endmodule

// File: rtl/devstate_ctl.sv
// devstate_ctl: top of the device state unit. Accepts one enable/disable
// request per cycle, answers the next cycle, and classifies status on demand.
// Assumes the requester tolerates a one-cycle response latency.
module devstate_ctl
    import devstate_pkg::*;
#(
    parameter int ID_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [ID_W-1:0] req_id,
    input  logic            req_op,
    output logic            rsp_valid,
    output logic            rsp_ok,
    input  logic [ID_W-1:0] qry_id,
    output logic [1:0]      qry_state,
    input  logic [31:0]     stat_word0,
    input  logic [31:0]     stat_word1,
    output logic [31:0]     ctrl_word0,
    output logic [31:0]     ctrl_word1
);

    logic              c_hit, c_can_off;
    logic [WSEL_W-1:0] c_wsel;
    logic [LSB_W-1:0]  c_lsb;
    logic [WORD_W-1:0] c_mask, c_on, c_off;

    logic              s_hit, s_can_off;
    logic [WSEL_W-1:0] s_wsel;
    logic [LSB_W-1:0]  s_lsb;
    logic [WORD_W-1:0] s_mask, s_on, s_off;

    logic                             accept;
    logic [WORD_W-1:0]                wr_code;
    logic [NUM_WORDS-1:0][WORD_W-1:0] cw;
    logic [NUM_WORDS-1:0][WORD_W-1:0] sw;

    devstate_field_decode #(.ID_W(ID_W), .N(CTL_N), .TAB(CTL_TAB)) i_ctl_dec (
        .id(req_id), .hit(c_hit), .wsel(c_wsel), .lsb(c_lsb), .mask(c_mask),
        .on_code(c_on), .off_code(c_off), .can_off(c_can_off)
    );

    devstate_field_decode #(.ID_W(ID_W), .N(STAT_N), .TAB(STAT_TAB)) i_stat_dec (
        .id(qry_id), .hit(s_hit), .wsel(s_wsel), .lsb(s_lsb), .mask(s_mask),
        .on_code(s_on), .off_code(s_off), .can_off(s_can_off)
    );

    // Acceptance: a known ID, and a disable only where the range allows it.
    always_comb begin
        accept  = req_valid && c_hit && (req_op || c_can_off);
        wr_code = req_op ? c_on : c_off;
    end

    devstate_ctl_regs i_regs (
        .clk(clk), .rst_n(rst_n), .we(accept), .wsel(c_wsel), .lsb(c_lsb),
        .mask(c_mask), .code(wr_code), .words(cw)
    );

    assign sw = {stat_word1, stat_word0};

    devstate_stat_class i_class (
        .words(sw), .hit(s_hit), .wsel(s_wsel), .lsb(s_lsb), .mask(s_mask),
        .on_code(s_on), .off_code(s_off), .state(qry_state)
    );

    // Response register: one answer per request, one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_ok    <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            rsp_ok    <= accept;
        end
    end

    assign ctrl_word0 = cw[0];
    assign ctrl_word1 = cw[1];

endmodule

// File: rtl/devstate_ctl_chk.sv
// devstate_ctl_chk: temporal properties of devstate_ctl, observed at its
// ports only. Bound to every instance of the top module.
module devstate_ctl_chk #(
    parameter int ID_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [ID_W-1:0] req_id,
    input logic            req_op,
    input logic            rsp_valid,
    input logic            rsp_ok,
    input logic [ID_W-1:0] qry_id,
    input logic [1:0]      qry_state,
    input logic [31:0]     ctrl_word0,
    input logic [31:0]     ctrl_word1
);

    p_rsp_follows_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    p_no_spurious_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(ctrl_word0) && $stable(ctrl_word1)));

    p_reject_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ok) |->
        (ctrl_word0 == $past(ctrl_word0) && ctrl_word1 == $past(ctrl_word1)));

    p_high_id_reject_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && 32'(req_id) > 14) |=> !rsp_ok);

    p_no_disable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op && (32'(req_id) == 13 || 32'(req_id) == 14))
        |=> !rsp_ok);

    p_word1_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ((ctrl_word1 & $past(ctrl_word1)) == $past(ctrl_word1)));

    p_unmapped_stat_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(qry_id) > 11) |-> (qry_state == 2'b11));

endmodule

bind devstate_ctl devstate_ctl_chk #(.ID_W(ID_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
    .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok), .qry_id(qry_id),
    .qry_state(qry_state), .ctrl_word0(ctrl_word0), .ctrl_word1(ctrl_word1)
);

// File: tb/test_devstate_ctl.sv
// test_devstate_ctl: sweeps every ID through enable/disable requests and every
// status field value, against an arithmetic model of the requirements.
module test_devstate_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [4:0]  req_id = '0;
    logic        req_op = 1'b0;
    logic        rsp_valid, rsp_ok;
    logic [4:0]  qry_id = '0;
    logic [1:0]  qry_state;
    logic [31:0] stat_word0 = '0;
    logic [31:0] stat_word1 = '0;
    logic [31:0] ctrl_word0, ctrl_word1;

    int total = 0;
    int bad   = 0;
    logic [31:0] m0 = '0;
    logic [31:0] m1 = '0;

    always #5 clk = ~clk;

    devstate_ctl i_devstate_ctl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
        .req_op(req_op), .rsp_valid(rsp_valid), .rsp_ok(rsp_ok),
        .qry_id(qry_id), .qry_state(qry_state), .stat_word0(stat_word0),
        .stat_word1(stat_word1), .ctrl_word0(ctrl_word0), .ctrl_word1(ctrl_word1)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Model of R2..R7: updates m0/m1 and yields the expected acceptance.
    task automatic model(input int id, input logic op, output logic ok, output string tag);
        ok = 1'b0;
        if (id <= 11) begin
            ok = 1'b1;
            m0[2*id +: 2] = op ? 2'b01 : 2'b00;
            tag = op ? "R2" : "R5";
        end else if (id == 12) begin
            ok = 1'b1;
            m0[31:30] = op ? 2'b11 : 2'b00;
            tag = "R3";
        end else if (id <= 14) begin
            ok = op;
            if (op) m1[id-13] = 1'b1;
            tag = op ? "R4" : "R6";
        end else begin
            tag = "R7";
        end
    endtask

    task automatic request(input int id, input logic op);
        logic ok;
        string tag;
        @(negedge clk);
        req_valid = 1'b1;
        req_id    = 5'(id);
        req_op    = op;
        model(id, op, ok, tag);
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " R9 response"}, {62'd0, rsp_valid, rsp_ok}, {62'd0, 1'b1, ok});
        check({tag, " R8 words"}, {ctrl_word0, ctrl_word1}, {m0, m1});
    endtask

    function automatic logic [1:0] exp_state(input int id, input logic [31:0] s0,
                                             input logic [31:0] s1);
        logic [2:0] f;
        if (id <= 9)       f = s0[3*id +: 3];
        else if (id <= 11) f = s1[3*(id-10) +: 3];
        else               return 2'b11;
        return (f == 3'd1) ? 2'b01 : (f == 3'd0) ? 2'b00 : 2'b10;
    endfunction

    initial begin
        // Watchdog.
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        req_valid = 1'b1;
        req_id    = 5'd3;
        req_op    = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 reset", {ctrl_word0, ctrl_word1}, 64'd0);
        check("R1 reset rsp", {63'd0, rsp_valid}, 64'd0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 idle no rsp", {63'd0, rsp_valid}, 64'd0);

        // Enable all, disable all, re-enable all: neighbours stay populated.
        for (int id = 0; id < 32; id++) request(id, 1'b1);
        for (int id = 0; id < 32; id++) request(id, 1'b0);
        for (int id = 31; id >= 0; id--) request(id, 1'b1);
        for (int id = 0; id < 32; id += 2) request(id, 1'b0);

        // R8: idle cycles with busy inputs leave the words untouched.
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            req_id = 5'(k * 5);
            req_op = k[0];
            @(negedge clk);
            check("R8 idle hold", {ctrl_word0, ctrl_word1}, {m0, m1});
            check("R9 idle no rsp", {63'd0, rsp_valid}, 64'd0);
        end

        // Status sweep: every ID, every field value, on a busy background.
        for (int id = 0; id < 32; id++) begin
            for (int v = 0; v < 8; v++) begin
                logic [31:0] s0, s1;
                string tag;
                s0 = 32'hB6DB_6DB6 ^ 32'(v * 37);
                s1 = 32'h9249_2492 ^ 32'(v * 11);
                if (id <= 9)       s0[3*id +: 3] = 3'(v);
                else if (id <= 11) s1[3*(id-10) +: 3] = 3'(v);
                tag = (id <= 9) ? "R10" : (id <= 11) ? "R11" : "R12";
                @(negedge clk);
                qry_id     = 5'(id);
                stat_word0 = s0;
                stat_word1 = s1;
                #1;
                check({tag, " status"}, {62'd0, qry_state}, {62'd0, exp_state(id, s0, s1)});
            end
        end

        // R12 with all-ones background.
        @(negedge clk);
        stat_word0 = '1;
        stat_word1 = '1;
        qry_id = 5'd20;
        #1;
        check("R12 unmapped", {62'd0, qry_state}, {62'd0, 2'b11});

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule